// File: doc/BRIEF.md
# SDRAM Open-Row Bank Command Sequencer

This block sits between a bus master that issues single reads and writes and a four-bank SDRAM device. For each accepted request it produces the SDRAM command sequence on a `{RAS#, CAS#, WE#}` command bus, together with the address, bank select and byte masks. It also runs periodic auto-refresh. A configuration bit picks one of two policies. With the bit at 0, every read or write carries the auto-precharge flag, so the row closes once the access completes. With the bit at 1, rows stay open and the block remembers the open row in each bank. A request to that row then goes straight to the column command. A request to another row first closes the bank and reopens it.

The master offers a request with `req_valid`. The request is taken on a clock edge where `req_ready` is high. `req_ready` stays low from that point until the sequence is over, and `req_ack` marks the cycle in which the column command is issued. Precharge, activate-to-column and write-recovery gaps come from configuration inputs. When CAS latency is 1, the block adds one idle cycle ahead of a read so that the byte mask leads the data by two cycles.

The controller has eleven states. `ST_IDLE` waits for work. Refresh goes first: IDLE to REF_PRE when a refresh is due. A row hit goes IDLE to RW, or IDLE to CAS_NOP for a CL1 read. A bank with another open row goes IDLE to PRE. A closed bank goes IDLE to ACT. The other transitions are: `ST_PRE` to `ST_PRE_WAIT` to `ST_ACT` to `ST_ACT_WAIT`, then to `ST_CAS_NOP` or `ST_RW`, then `ST_CAS_NOP` to `ST_RW`. From there, `ST_RW` goes to `ST_RECOVER` in auto-precharge mode and to `ST_IDLE` in bank-active mode. `ST_RECOVER` goes to `ST_IDLE`. The refresh path is `ST_REF_PRE` to `ST_REF_WAIT` to `ST_REF` to `ST_IDLE`.

Top module: `sdram_row_sequencer`

## Requirements
- R1: A READ or WRIT command drives address bit 10 high when `cfg_bank_active` is 0 (auto-precharge form) and low when it is 1.
- R2: In bank-active mode, a request to the row already open in its bank issues no PRE and no ACT. The READ or WRIT appears in the first cycle after acceptance, or in the second cycle for a read at CAS latency 1.
- R3: In bank-active mode, a request to a bank holding a different open row produces this sequence. First PRE, with address bit 10 low and `sd_ba` set to the bank. Then `cfg_trp`+1 NOP cycles. Then ACT carrying the new row. Then `cfg_trcd`+1 NOP cycles. Then READ or WRIT.
- R4: A request to a bank with no open row starts with ACT carrying the row on `sd_addr` and the bank on `sd_ba`, with no PRE. It is followed by `cfg_trcd`+1 NOP cycles before READ or WRIT. In auto-precharge mode every request takes this path.
- R5: After WRITA, `req_ready` stays low for `cfg_twr`+1 further NOP cycles. After READA it stays low for `cfg_trp`+1. In bank-active mode `req_ready` returns in the cycle right after the READ or WRIT.
- R6: At `cfg_cas_lat`=1, exactly one NOP is placed directly before READ. That NOP already drives `sd_dqm` with the request mask. Writes, and reads at any other latency, get no such NOP.
- R7: `sd_dqm` equals the request mask during the READ or WRIT cycle. It is all ones in every cycle other than that one and the R6 NOP.
- R8: Once `cfg_ref_interval` cycles have elapsed, `req_ready` drops at the next idle point. The block then issues PRE with bit 10 high, then `cfg_trp`+1 NOP cycles, then REF. All rows are closed afterwards, so the next access starts with ACT.
- R9: After reset, `sd_cmd` is NOP, `sd_dqm` is all ones, `req_ack` is 0, `req_ready` is 1 and no bank has an open row.
- R10: The command codes on `sd_cmd` {RAS#,CAS#,WE#} are NOP=111, ACT=011, READ=101, WRIT=100, PRE=010 and REF=001.
- R11: `req_ack` is high for exactly one cycle per accepted request, in the cycle the READ or WRIT is issued, and `req_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| req_mask | input | 2 | Byte mask, 1 = byte masked |
| cfg_bank_active | input | 1 | 1 = keep rows open, 0 = auto-precharge |
| cfg_trp | input | 2 | Precharge gap, value+1 idle cycles |
| cfg_trcd | input | 2 | Activate-to-column gap, value+1 idle cycles |
| cfg_twr | input | 3 | Write recovery after WRITA, value+1 idle cycles |
| cfg_cas_lat | input | 2 | CAS latency |
| cfg_ref_interval | input | 16 | Cycles between refreshes |
| req_ready | output | 1 | Block can accept a request |
| req_ack | output | 1 | Column command issued for the current request |
| sd_cmd | output | 3 | {RAS#, CAS#, WE#} command |
| sd_addr | output | 13 | Row, or column with bit 10 as precharge flag |
| sd_ba | output | 2 | Bank select |
| sd_dqm | output | 2 | Byte masks toward the device |

## Verification
A stale or wrong entry in the open-row table shows at the ports on the very first command after the next request to that bank. It appears as a missing or spurious PRE or ACT, or as an ACT carrying the wrong row. A wrong wait count shifts the ACT or the column command by whole cycles, so the bench compares the whole command sequence cycle by cycle, and it counts the exact cycle in which `req_ready` returns. A refresh that fails to clear the table shows up as a row hit on the access right after REF, where an ACT is expected.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
    typedef enum logic [2:0] {
        CMD_REF  = 3'b001,
        CMD_PRE  = 3'b010,
        CMD_ACT  = 3'b011,
        CMD_WRIT = 3'b100,
        CMD_READ = 3'b101,
        CMD_NOP  = 3'b111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_PRE_WAIT,
        ST_ACT,
        ST_ACT_WAIT,
        ST_CAS_NOP,
        ST_RW,
        ST_RECOVER,
        ST_REF_PRE,
        ST_REF_WAIT,
        ST_REF
    } seq_state_e;
endpackage

// File: rtl/sdr_open_rows.sv
module sdr_open_rows #(
    parameter int BANKS = 4,
    parameter int ROW_W = 13,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              clear_all,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    output logic              look_open,
    output logic              look_hit
);
    logic [BANKS-1:0] row_vld;
    logic [ROW_W-1:0] row_tag [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                row_vld[b] <= 1'b0;
                row_tag[b] <= '0;
            end else if (set_en && set_bank == BANK_W'(b)) begin
                row_vld[b] <= 1'b1;
                row_tag[b] <= set_row;
            end
        end
    end

    always_comb begin
        look_open = row_vld[look_bank];
        look_hit  = look_open && (row_tag[look_bank] == look_row);
    end

    AST_CLEAR_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (row_vld == '0)); // R8
    AST_SET_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clear_all) |=> row_vld[$past(set_bank)]); // R4
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval,
    input  logic             ref_done,
    output logic             ref_pending
);
    logic [CNT_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed     <= '0;
            ref_pending <= 1'b0;
        end else begin
            if (elapsed >= interval) begin
                elapsed     <= '0;
                ref_pending <= 1'b1;
            end else begin
                elapsed <= elapsed + 1'b1;
                if (ref_done) ref_pending <= 1'b0;
            end
        end
    end

    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pending && !ref_done) |=> ref_pending); // R8
endmodule

// File: rtl/sdram_row_sequencer.sv
module sdram_row_sequencer
    import sdr_seq_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int MASK_W = 2,
    parameter int TWR_W  = 3,
    parameter int REF_W  = 16,
    localparam int BANK_W = $clog2(BANKS),
    localparam int AP_BIT = 10,
    localparam int WAIT_W = (TWR_W > 2) ? TWR_W : 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [MASK_W-1:0] req_mask,
    input  logic              cfg_bank_active,
    input  logic [1:0]        cfg_trp,
    input  logic [1:0]        cfg_trcd,
    input  logic [TWR_W-1:0]  cfg_twr,
    input  logic [1:0]        cfg_cas_lat,
    input  logic [REF_W-1:0]  cfg_ref_interval,
    output logic              req_ready,
    output logic              req_ack,
    output logic [2:0]        sd_cmd,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic [MASK_W-1:0] sd_dqm
);
    seq_state_e        state, nxt;
    logic [WAIT_W-1:0] wait_cnt, cnt_nxt;
    logic              c_write;
    logic [BANK_W-1:0] c_bank;
    logic [ROW_W-1:0]  c_row;
    logic [COL_W-1:0]  c_col;
    logic [MASK_W-1:0] c_mask;
    logic              row_open, row_hit, ref_pending, accept, cl1;
    sdr_cmd_e          cmd;

    assign cl1    = (cfg_cas_lat == 2'd1);
    assign accept = (state == ST_IDLE) && !ref_pending && req_valid;

    sdr_open_rows #(.BANKS(BANKS), .ROW_W(ROW_W)) i_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   ((state == ST_ACT) && cfg_bank_active),
        .set_bank (c_bank),
        .set_row  (c_row),
        .clear_all(state == ST_REF),
        .look_bank(req_bank),
        .look_row (req_row),
        .look_open(row_open),
        .look_hit (row_hit)
    );

    sdr_refresh_timer #(.CNT_W(REF_W)) i_refresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .interval   (cfg_ref_interval),
        .ref_done   (state == ST_REF),
        .ref_pending(ref_pending)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            c_write  <= 1'b0;
            c_bank   <= '0;
            c_row    <= '0;
            c_col    <= '0;
            c_mask   <= '0;
        end else begin
            state    <= nxt;
            wait_cnt <= cnt_nxt;
            if (accept) begin
                c_write <= req_write;
                c_bank  <= req_bank;
                c_row   <= req_row;
                c_col   <= req_col;
                c_mask  <= req_mask;
            end
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = (wait_cnt != '0) ? wait_cnt - 1'b1 : '0;
        unique case (state)
            ST_IDLE: begin
                if (ref_pending)   nxt = ST_REF_PRE;
                else if (req_valid) begin
                    if (row_hit && cfg_bank_active)
                        nxt = (!req_write && cl1) ? ST_CAS_NOP : ST_RW;
                    else if (row_open && cfg_bank_active)
                        nxt = ST_PRE;
                    else
                        nxt = ST_ACT;
                end
            end
            ST_PRE:      begin nxt = ST_PRE_WAIT; cnt_nxt = WAIT_W'(cfg_trp); end
            ST_PRE_WAIT: if (wait_cnt == '0) nxt = ST_ACT;
            ST_ACT:      begin nxt = ST_ACT_WAIT; cnt_nxt = WAIT_W'(cfg_trcd); end
            ST_ACT_WAIT: if (wait_cnt == '0) nxt = (!c_write && cl1) ? ST_CAS_NOP : ST_RW;
            ST_CAS_NOP:  nxt = ST_RW;
            ST_RW: begin
                if (cfg_bank_active) nxt = ST_IDLE;
                else begin
                    nxt     = ST_RECOVER;
                    cnt_nxt = c_write ? WAIT_W'(cfg_twr) : WAIT_W'(cfg_trp);
                end
            end
            ST_RECOVER:  if (wait_cnt == '0) nxt = ST_IDLE;
            ST_REF_PRE:  begin nxt = ST_REF_WAIT; cnt_nxt = WAIT_W'(cfg_trp); end
            ST_REF_WAIT: if (wait_cnt == '0) nxt = ST_REF;
            ST_REF:      nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        sd_ba     = c_bank;
        sd_dqm    = '1;
        req_ack   = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = !ref_pending;
            ST_PRE:     cmd = CMD_PRE;
            ST_ACT:     begin cmd = CMD_ACT; sd_addr = c_row; end
            ST_CAS_NOP: sd_dqm = c_mask;
            ST_RW: begin
                cmd             = c_write ? CMD_WRIT : CMD_READ;
                sd_addr         = ROW_W'(c_col);
                sd_addr[AP_BIT] = !cfg_bank_active;
                sd_dqm          = c_mask;
                req_ack         = 1'b1;
            end
            ST_REF_PRE: begin cmd = CMD_PRE; sd_addr[AP_BIT] = 1'b1; end
            ST_REF:     cmd = CMD_REF;
            default:    cmd = CMD_NOP;
        endcase
        sd_cmd = cmd;
    end

    AST_AP_FLAG_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_READ || sd_cmd == CMD_WRIT) |-> (sd_addr[AP_BIT] == !cfg_bank_active)); // R1
    AST_PRE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_PRE) |=> (sd_cmd == CMD_NOP)); // R3
    AST_ACT_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_ACT) |=> (sd_cmd == CMD_NOP)); // R4
    AST_CL1_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_READ && cfg_cas_lat == 2'd1) |-> ($past(sd_cmd) == CMD_NOP)); // R6
    AST_ACK_WITH_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> ((sd_cmd == CMD_READ || sd_cmd == CMD_WRIT) && !req_ready)); // R11
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R11
endmodule

// File: tb/test_sdram_row_sequencer.sv
module test_sdram_row_sequencer;
    localparam int NLOG = 40;
    localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_READ = 3'b101,
                           C_WRIT = 3'b100, C_PRE = 3'b010, C_REF = 3'b001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_bank = 0, req_mask = 0;
    logic [12:0] req_row = 0;
    logic [9:0] req_col = 0;
    logic cfg_bank_active = 0;
    logic [1:0] cfg_trp = 2'd1, cfg_trcd = 2'd1, cfg_cas_lat = 2'd2;
    logic [2:0] cfg_twr = 3'd2;
    logic [15:0] cfg_ref_interval = 16'hFFFF;
    logic req_ready, req_ack;
    logic [2:0] sd_cmd;
    logic [12:0] sd_addr;
    logic [1:0] sd_ba, sd_dqm;

    int n_tests = 0, n_fail = 0;
    logic [2:0]  lg_cmd  [NLOG];
    logic [12:0] lg_addr [NLOG];
    logic [1:0]  lg_ba   [NLOG];
    logic [1:0]  lg_dqm  [NLOG];
    logic        lg_ack  [NLOG];
    logic        lg_rdy  [NLOG];

    always #2 clk = ~clk;

    sdram_row_sequencer i_sdram_row_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_mask(req_mask),
        .cfg_bank_active(cfg_bank_active), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
        .cfg_twr(cfg_twr), .cfg_cas_lat(cfg_cas_lat), .cfg_ref_interval(cfg_ref_interval),
        .req_ready(req_ready), .req_ack(req_ack), .sd_cmd(sd_cmd), .sd_addr(sd_addr),
        .sd_ba(sd_ba), .sd_dqm(sd_dqm));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // kind: 0 = open-row hit, 1 = closed bank (ACT first), 2 = other row open (PRE first)
    task automatic access(input bit w, input logic [1:0] bank, input logic [12:0] row,
                          input logic [9:0] col, input logic [1:0] mask, input int kind, input string req);
        int act_idx, rw, rdy_idx, bad_idx;
        bit nop1;
        logic [2:0] exp_cmd;
        @(negedge clk);
        req_valid = 1; req_write = w; req_bank = bank; req_row = row; req_col = col; req_mask = mask;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < NLOG; i++) begin
            lg_cmd[i] = sd_cmd; lg_addr[i] = sd_addr; lg_ba[i] = sd_ba;
            lg_dqm[i] = sd_dqm; lg_ack[i] = req_ack; lg_rdy[i] = req_ready;
            @(negedge clk);
        end
        nop1    = !w && (cfg_cas_lat == 2'd1);
        act_idx = (kind == 2) ? int'(cfg_trp) + 2 : 0;
        rw      = (kind == 0) ? 0 : act_idx + int'(cfg_trcd) + 2;
        if (nop1) rw++;
        bad_idx = -1;
        for (int i = 0; i <= rw; i++) begin
            exp_cmd = C_NOP;
            if (i == rw) exp_cmd = w ? C_WRIT : C_READ;
            else if (kind == 2 && i == 0) exp_cmd = C_PRE;
            else if (kind >= 1 && i == act_idx) exp_cmd = C_ACT;
            if (lg_cmd[i] != exp_cmd && bad_idx < 0) bad_idx = i;
        end
        chk(bad_idx < 0, req, "command sequence, first bad cycle", bad_idx, -1);
        chk(lg_ack[rw] == 1'b1 && lg_ba[rw] == bank, "R11", "ack and bank at column cmd", int'(lg_ack[rw]), 1);
        chk(lg_addr[rw][10] == !cfg_bank_active, "R1", "address bit 10 at column cmd",
            int'(lg_addr[rw][10]), int'(!cfg_bank_active));
        chk(lg_addr[rw][9:0] == col, "R2", "column address", int'(lg_addr[rw][9:0]), int'(col));
        chk(lg_dqm[rw] == mask && lg_dqm[rw+1] == 2'b11, "R7", "dqm at and after column cmd",
            int'(lg_dqm[rw]), int'(mask));
        if (nop1)
            chk(lg_dqm[rw-1] == mask, "R6", "dqm in pre-read NOP", int'(lg_dqm[rw-1]), int'(mask));
        if (kind >= 1)
            chk(lg_addr[act_idx] == row && lg_ba[act_idx] == bank, "R4", "ACT row",
                int'(lg_addr[act_idx]), int'(row));
        if (kind == 2)
            chk(lg_ba[0] == bank && lg_addr[0][10] == 1'b0, "R3", "PRE bank/A10",
                int'(lg_ba[0]), int'(bank));
        rdy_idx = cfg_bank_active ? rw + 1 : rw + 2 + (w ? int'(cfg_twr) : int'(cfg_trp));
        chk(lg_rdy[rdy_idx] == 1'b1 && lg_rdy[rdy_idx-1] == 1'b0, "R5", "ready return cycle",
            int'(lg_rdy[rdy_idx]), 1);
    endtask

    task automatic t_reset();
        chk(sd_cmd == C_NOP, "R9", "reset command (R10 NOP code)", int'(sd_cmd), int'(C_NOP));
        chk(req_ready == 1'b1 && req_ack == 1'b0 && sd_dqm == 2'b11, "R9", "reset ready/ack/dqm",
            int'({req_ready, req_ack, sd_dqm}), 4'b1011);
    endtask

    task automatic t_refresh();
        int waited = 0;
        bit bad = 0;
        @(negedge clk);
        cfg_ref_interval = 16'd20;
        while (sd_cmd != C_PRE && waited < 100) begin @(negedge clk); waited++; end
        chk(sd_cmd == C_PRE && sd_addr[10] == 1'b1 && !req_ready, "R8", "PRE-all issued", int'(sd_cmd), int'(C_PRE));
        for (int i = 0; i <= int'(cfg_trp); i++) begin
            @(negedge clk);
            if (sd_cmd != C_NOP) bad = 1;
        end
        chk(!bad, "R8", "NOPs after PRE-all", int'(bad), 0);
        @(negedge clk);
        chk(sd_cmd == C_REF, "R8", "REF command", int'(sd_cmd), int'(C_REF));
        cfg_ref_interval = 16'hFFFF;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready after REF", int'(req_ready), 1);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        access(1, 2'd0, 13'd5, 10'h012, 2'b00, 1, "R4");
        access(0, 2'd0, 13'd5, 10'h013, 2'b10, 1, "R4");
        cfg_bank_active = 1;
        access(0, 2'd1, 13'd7, 10'h020, 2'b00, 1, "R4");
        access(0, 2'd1, 13'd7, 10'h021, 2'b00, 0, "R2");
        access(1, 2'd1, 13'd7, 10'h022, 2'b01, 0, "R2");
        cfg_trp = 2'd2; cfg_trcd = 2'd0;
        access(0, 2'd1, 13'd9, 10'h030, 2'b00, 2, "R3");
        access(1, 2'd2, 13'd7, 10'h040, 2'b11, 1, "R4");
        access(0, 2'd1, 13'd9, 10'h031, 2'b00, 0, "R2");
        cfg_cas_lat = 2'd1;
        access(0, 2'd1, 13'd9, 10'h032, 2'b10, 0, "R6");
        access(1, 2'd1, 13'd9, 10'h033, 2'b01, 0, "R6");
        access(0, 2'd2, 13'd8, 10'h034, 2'b01, 2, "R6");
        cfg_cas_lat = 2'd2;
        t_refresh();
        access(0, 2'd1, 13'd9, 10'h050, 2'b00, 1, "R8");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule